// File: doc/BRIEF.md
# Nibble-Sliced Shift-Register CAM

This block is a content addressable memory with one-clock search. Each stored word is split into 4-bit slices. Each slice of each entry is held as a 16-bit register that works as a lookup table: bit `k` is set when slice value `k` should count as a match. A search uses every slice of the key to select one bit from that slice's register in every entry. An entry hits when all of its selected bits are 1 and the entry holds valid content. The block registers a per-entry hit vector, a hit flag and the index of the lowest hitting entry one clock after the search strobe.

Loading an entry is serial. After a write start, the block shifts one bit into every slice register of the addressed entry on each of 16 clocks, beginning with the bit for slice value 15 and ending with the bit for value 0. A per-bit care mask comes with the data. A bit whose care bit is 0 takes no part in the comparison, so any search value matches it. While a load is running the block raises a busy flag. It ignores both search strobes and new write starts until the load ends, so a search never sees a half-loaded entry.

Word width and word depth are parameters. The depth is meant to be a multiple of 16 with a minimum of 32, for example 128 x 104 or 32 x 160. When the width is not a multiple of 4, the top slice is padded with masked bits.

Top module: `srl_cam`

## Requirements
- R1: When `srch_en` is high and `wr_busy` is low at a clock edge, `hit_vec[e]` after that edge is 1 exactly when entry `e` holds valid content and every cared bit of `srch_key` equals the stored bit.
- R2: A bit whose `wr_care` bit was 0 when the entry was written is don't-care: the entry matches for both key values of that bit. An entry written with all care bits 0 matches every key.
- R3: After an accepted search, `hit` is 1 when any bit of `hit_vec` is 1, and `hit_addr` is the lowest index whose `hit_vec` bit is 1. When no entry matches, `hit` is 0 and `hit_vec` is all zeros.
- R4: A `wr_start` sampled while `wr_busy` is low makes `wr_busy` high for exactly 16 clock cycles. The entry at `wr_addr` then holds `wr_data` under mask `wr_care`, and a search issued on the next cycle reports it.
- R5: After reset, `wr_busy`, `hit`, `hit_vec` and `hit_addr` are 0, and no entry matches any key until it has been written. Reset also invalidates all previously written entries.
- R6: While `wr_busy` is high, a search strobe leaves `hit`, `hit_vec` and `hit_addr` unchanged, and a `wr_start` is ignored: the running load finishes on time and the second address is not written.
- R7: With `srch_en` low, `hit`, `hit_vec` and `hit_addr` keep their values whatever `srch_key` does.
- R8: Writing an entry again replaces its old content, so the old value no longer matches that entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low global reset; clears outputs and invalidates all entries |
| srch_en | input | 1 | Search strobe |
| srch_key | input | WIDTH | Search key |
| wr_start | input | 1 | Starts a 16-cycle load of one entry |
| wr_addr | input | $clog2(DEPTH) | Entry index to load |
| wr_data | input | WIDTH | Content to store |
| wr_care | input | WIDTH | Per-bit compare mask, 1 = compare, 0 = don't care |
| wr_busy | output | 1 | High while a load is shifting |
| hit | output | 1 | At least one entry matched the last accepted search |
| hit_vec | output | DEPTH | Per-entry match result of the last accepted search |
| hit_addr | output | $clog2(DEPTH) | Lowest matching entry index |

## Verification
The hardest case to bring about is a second search and a second write arriving in the middle of a load. Only then can a half-shifted entry leak into a result or a load be restarted. The bench sets the search strobe and a write start to another address partway through a load. It then checks that the outputs did not move, that busy still lasts exactly 16 cycles and that only the first address took new content. A full sweep of all 256 keys on an 8-bit, 32-entry configuration is repeated after reset, after loads with masks and duplicate values, after a match-everything entry and after an overwrite. Every hit vector and address is compared against an arithmetic model.

// File: rtl/srl_cam_pkg.sv
package srl_cam_pkg;
    localparam int SLICE_W   = 4;
    localparam int SLICE_VAL = 16;

    function automatic int slices_for(input int width);
        return (width + SLICE_W - 1) / SLICE_W;
    endfunction
endpackage

// File: rtl/srl_cam_loader.sv
module srl_cam_loader
    import srl_cam_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int AW    = 5,
    parameter int NSL   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_start,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [WIDTH-1:0] wr_care,
    output logic             busy,
    output logic             last,
    output logic [AW-1:0]    sel,
    output logic [NSL-1:0]   bits
);
    localparam int PW = NSL * SLICE_W;

    typedef struct packed {
        logic          busy;
        logic [3:0]    cnt;
        logic [AW-1:0] addr;
        logic [PW-1:0] data;
        logic [PW-1:0] care;
    } ld_t;

    ld_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            st_d.cnt = st_q.cnt + 4'd1;
            if (st_q.cnt == 4'd15) st_d.busy = 1'b0;
        end else if (wr_start) begin
            st_d.busy = 1'b1;
            st_d.cnt  = 4'd0;
            st_d.addr = wr_addr;
            st_d.data = PW'(wr_data);
            st_d.care = PW'(wr_care);
        end
    end

    // value presented on this shift step counts down from 15 to 0
    always_comb begin
        for (int n = 0; n < NSL; n++) begin
            bits[n] = ((st_q.data[n*SLICE_W +: SLICE_W] ^ ~st_q.cnt)
                       & st_q.care[n*SLICE_W +: SLICE_W]) == 4'd0;
        end
    end

    assign busy = st_q.busy;
    assign last = st_q.busy && (st_q.cnt == 4'd15);
    assign sel  = st_q.addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/srl_cam_entry.sv
module srl_cam_entry
    import srl_cam_pkg::*;
#(
    parameter int NSL = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 shift,
    input  logic                 last,
    input  logic [NSL-1:0]       bits,
    input  logic [NSL*4-1:0]     key,
    output logic                 match
);
    typedef struct packed {
        logic                  valid;
        logic [NSL-1:0][15:0]  tbl;
    } ent_t;

    ent_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift) begin
            for (int n = 0; n < NSL; n++) begin
                st_d.tbl[n] = {st_q.tbl[n][14:0], bits[n]};
            end
            st_d.valid = last;
        end
    end

    always_comb begin
        match = st_q.valid;
        for (int n = 0; n < NSL; n++) begin
            match = match & st_q.tbl[n][key[n*SLICE_W +: SLICE_W]];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/srl_cam_prio.sv
module srl_cam_prio #(
    parameter int DEPTH = 32,
    parameter int AW    = 5
) (
    input  logic [DEPTH-1:0] vec,
    output logic             found,
    output logic [AW-1:0]    idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int e = DEPTH - 1; e >= 0; e--) begin
            if (vec[e]) begin
                found = 1'b1;
                idx   = AW'(e);
            end
        end
    end
endmodule

// File: rtl/srl_cam.sv
module srl_cam
    import srl_cam_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             srch_en,
    input  logic [WIDTH-1:0] srch_key,
    input  logic             wr_start,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [WIDTH-1:0] wr_care,
    output logic             wr_busy,
    output logic             hit,
    output logic [DEPTH-1:0] hit_vec,
    output logic [AW-1:0]    hit_addr
);
    localparam int NSL = slices_for(WIDTH);
    localparam int PW  = NSL * SLICE_W;

    typedef struct packed {
        logic             hit;
        logic [DEPTH-1:0] vec;
        logic [AW-1:0]    addr;
    } res_t;

    res_t res_d, res_q;

    logic             ld_busy, ld_last;
    logic [AW-1:0]    ld_sel;
    logic [NSL-1:0]   ld_bits;
    logic [PW-1:0]    key_pad;
    logic [DEPTH-1:0] mvec;
    logic             p_found;
    logic [AW-1:0]    p_idx;

    assign key_pad = PW'(srch_key);

    srl_cam_loader #(.WIDTH(WIDTH), .AW(AW), .NSL(NSL)) u_ld (
        .clk(clk), .rst_n(rst_n),
        .wr_start(wr_start), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_care(wr_care),
        .busy(ld_busy), .last(ld_last), .sel(ld_sel), .bits(ld_bits)
    );

    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        srl_cam_entry #(.NSL(NSL)) u_ent (
            .clk(clk), .rst_n(rst_n),
            .shift(ld_busy && (ld_sel == AW'(e))),
            .last(ld_last),
            .bits(ld_bits),
            .key(key_pad),
            .match(mvec[e])
        );
    end

    srl_cam_prio #(.DEPTH(DEPTH), .AW(AW)) u_prio (
        .vec(mvec), .found(p_found), .idx(p_idx)
    );

    always_comb begin
        res_d = res_q;
        if (srch_en && !ld_busy) begin
            res_d.hit  = p_found;
            res_d.vec  = mvec;
            res_d.addr = p_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign wr_busy  = ld_busy;
    assign hit      = res_q.hit;
    assign hit_vec  = res_q.vec;
    assign hit_addr = res_q.addr;
endmodule

// File: rtl/srl_cam_chk.sv
module srl_cam_chk #(
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             srch_en,
    input logic             wr_start,
    input logic             wr_busy,
    input logic             hit,
    input logic [DEPTH-1:0] hit_vec,
    input logic [AW-1:0]    hit_addr
);
    logic [4:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       run_q <= '0;
        else if (wr_busy) run_q <= run_q + 5'd1;
        else              run_q <= '0;
    end

    a_r4_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_start && !wr_busy) |=> wr_busy);

    a_r4_busy_short: assert property (@(posedge clk) disable iff (!rst_n)
        wr_busy |-> run_q < 5'd16);

    a_r4_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_busy) |-> run_q == 5'd16);

    a_r3_addr_hits: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> hit_vec[hit_addr]);

    a_r3_lowest: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (hit_vec & ((DEPTH'(1) << hit_addr) - DEPTH'(1))) == '0);

    a_r3_nohit_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> hit_vec == '0);

    a_r6_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
        wr_busy |=> ($stable(hit_vec) && $stable(hit_addr) && $stable(hit)));

    a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !srch_en |=> ($stable(hit_vec) && $stable(hit_addr) && $stable(hit)));
endmodule

bind srl_cam srl_cam_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .srch_en(srch_en), .wr_start(wr_start),
    .wr_busy(wr_busy), .hit(hit), .hit_vec(hit_vec), .hit_addr(hit_addr)
);

// File: tb/srl_cam_tb.sv
module srl_cam_tb;
    localparam int W  = 8;
    localparam int D  = 32;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          srch_en = 1'b0;
    logic [W-1:0]  srch_key = '0;
    logic          wr_start = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [W-1:0]  wr_data = '0;
    logic [W-1:0]  wr_care = '0;
    logic          wr_busy, hit;
    logic [D-1:0]  hit_vec;
    logic [AW-1:0] hit_addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [W-1:0] m_data [D];
    logic [W-1:0] m_care [D];
    logic         m_val  [D];

    always #4 clk = ~clk;

    srl_cam #(.WIDTH(W), .DEPTH(D)) u_dut (
        .clk(clk), .rst_n(rst_n), .srch_en(srch_en), .srch_key(srch_key),
        .wr_start(wr_start), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_care(wr_care), .wr_busy(wr_busy), .hit(hit),
        .hit_vec(hit_vec), .hit_addr(hit_addr)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [D-1:0] exp_vec(input logic [W-1:0] k);
        logic [D-1:0] v = '0;
        for (int e = 0; e < D; e++)
            v[e] = m_val[e] && (((k ^ m_data[e]) & m_care[e]) == '0);
        return v;
    endfunction

    function automatic logic [AW-1:0] exp_addr(input logic [D-1:0] v);
        for (int e = 0; e < D; e++) if (v[e]) return AW'(e);
        return '0;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        for (int e = 0; e < D; e++) m_val[e] = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic search(input logic [W-1:0] k, input string req);
        logic [D-1:0] ev;
        @(negedge clk);
        srch_en = 1'b1;
        srch_key = k;
        @(negedge clk);
        srch_en = 1'b0;
        ev = exp_vec(k);
        chk(hit_vec == ev && hit == (ev != '0) && hit_addr == exp_addr(ev), req,
            {hit, 3'b0, hit_addr, 24'b0, hit_vec},
            {(ev != '0), 3'b0, exp_addr(ev), 24'b0, ev});
    endtask

    task automatic sweep(input string req);
        for (int k = 0; k < 256; k++) search(W'(k), req);
    endtask

    // inj: mid-load search and second write start (R6)
    task automatic write(input logic [AW-1:0] a, input logic [W-1:0] d,
                         input logic [W-1:0] c, input bit inj);
        int bc = 0;
        logic [D-1:0]  sv_vec;
        logic [AW-1:0] sv_addr;
        logic          sv_hit;
        @(negedge clk);
        wr_start = 1'b1; wr_addr = a; wr_data = d; wr_care = c;
        @(negedge clk);
        wr_start = 1'b0;
        sv_vec = hit_vec; sv_addr = hit_addr; sv_hit = hit;
        for (int i = 0; i < 20; i++) begin
            if (wr_busy) bc++;
            srch_en = 1'b0;
            wr_start = 1'b0;
            if (inj && i == 3) begin
                srch_en = 1'b1; srch_key = 8'h3C;
                wr_start = 1'b1; wr_addr = a ^ 5'd1; wr_data = 8'h77; wr_care = 8'hFF;
            end
            @(negedge clk);
        end
        chk(bc == 16, "R4 busy length", bc, 16);
        if (inj) begin
            chk(hit_vec == sv_vec && hit_addr == sv_addr && hit == sv_hit,
                "R6 search during load ignored", {hit_addr, hit_vec}, {sv_addr, sv_vec});
        end
        m_data[a] = d; m_care[a] = c; m_val[a] = 1'b1;
    endtask

    initial begin
        for (int e = 0; e < D; e++) begin
            m_data[e] = '0; m_care[e] = '0; m_val[e] = 1'b0;
        end
        do_reset();
        chk(wr_busy == 1'b0 && hit == 1'b0 && hit_vec == '0 && hit_addr == '0,
            "R5 reset outputs", {wr_busy, hit, hit_addr, hit_vec}, 0);
        sweep("R5 empty never matches");

        write(5'd3,  8'hA5, 8'hFF, 1'b0);
        search(8'hA5, "R4 entry visible next cycle");
        write(5'd7,  8'hA5, 8'hFF, 1'b0);
        write(5'd10, 8'h3C, 8'hF0, 1'b0);
        write(5'd12, 8'h81, 8'h81, 1'b0);
        write(5'd31, 8'h5A, 8'h0F, 1'b0);
        write(5'd0,  8'h11, 8'hFF, 1'b0);
        sweep("R1 R2 R3 masked and duplicate entries");

        // R7: key changes with strobe low, outputs hold
        search(8'hA5, "R3 lowest of duplicates");
        @(negedge clk);
        srch_key = 8'h3C;
        repeat (2) @(negedge clk);
        chk(hit_addr == 5'd3 && hit_vec == exp_vec(8'hA5), "R7 idle hold",
            {hit_addr, hit_vec}, {5'd3, exp_vec(8'hA5)});

        // R6: mid-load search and write start; entry 2 must stay unwritten
        search(8'hA5, "R1 before injected load");
        write(5'd3, 8'h42, 8'hFF, 1'b1);
        search(8'h77, "R6 second start ignored");
        search(8'h42, "R8 overwrite new value");
        search(8'hA5, "R8 old value gone from entry");
        sweep("R8 after overwrite");

        write(5'd20, 8'h00, 8'h00, 1'b0);
        sweep("R2 all don't-care entry");

        do_reset();
        sweep("R5 reset invalidates entries");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule